// File: doc/BRIEF.md
# Trigger-Driven Derandomizing Buffer Controller

This block sits between a set of front-end units and a serial readout path. It holds a small number of event hit patterns while the second-level trigger decides their fate. Each first-level trigger captures the current hit pattern, one bit field per front-end unit, into the lowest-numbered empty slot of the buffer. Second-level decisions are matched to the waiting events oldest first. An accepted event is queued for readout, and a rejected event simply gives its slot back.

Readout walks the front-end units in ascending order. It shifts each unit's field out one bit per cycle on a single serial line and shows the number of the unit being sent next to it. Events are read out one at a time, in the order they were accepted. New triggers keep filling free slots while a readout is running. When every slot is taken, a busy flag tells the acquisition control to hold off. Any trigger that still arrives while busy is dropped and counted.

Top module: `derand_buffer_ctrl`

## Requirements
- R1: When `l1_trig` is high and `busy` is low, `hit_pat` is captured into a free slot at that clock edge. This includes cycles while a readout is in progress.
- R2: `busy` is high exactly when all NUM_SLOTS slots are held. A slot is held from its capture until it is rejected or its readout ends.
- R3: When `l1_trig` is high while `busy` is high, nothing is stored and `l1_err_cnt` increases by one. The count saturates at 2^ERR_W-1.
- R4: Each second-level decision applies to the oldest pending event, in first-level trigger order. An event captured in the same cycle is not yet pending. A decision with no event pending is ignored and produces no output.
- R5: If `l2_accept` and `l2_reject` are high in the same cycle, the decision is an accept.
- R6: A rejected event is never put on the serial output. Its slot is free again in the next cycle.
- R7: An event is sent as NUM_UNITS*UNIT_W consecutive cycles with `ser_valid` high. Units are sent as 0, 1, ..., NUM_UNITS-1, and each unit is sent least significant bit first. Unit u bit b is `hit_pat[u*UNIT_W+b]`, and `ser_unit` equals u while that unit is being sent.
- R8: Accepted events are sent in the order they were accepted. Each event finishes before the next one starts, with at least one cycle of `ser_valid` low between events.
- R9: The slot of an event that has been read out is free in the cycle after its last bit.
- R10: After reset, `busy`, `ser_valid` and `l1_err_cnt` are all zero, and no event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| l1_trig | input | 1 | First-level trigger pulse |
| hit_pat | input | NUM_UNITS*UNIT_W | Current hit pattern, UNIT_W bits per unit |
| l2_accept | input | 1 | Second-level accept for the oldest pending event |
| l2_reject | input | 1 | Second-level reject for the oldest pending event |
| busy | output | 1 | All slots held |
| l1_err_cnt | output | ERR_W | Saturating count of triggers lost while busy |
| ser_valid | output | 1 | Serial bit valid |
| ser_data | output | 1 | Serial data bit |
| ser_unit | output | clog2(NUM_UNITS) | Unit whose field is being sent |

## Verification
The bench builds the block with four slots, ten units, four-bit unit fields and a four-bit error counter. The four-bit counter makes saturation reachable after fifteen lost triggers. The short unit fields keep each readout to forty cycles. At that readout length, random trigger traffic fills all four slots often, and accepts arrive while an earlier event is still being sent. Directed steps cover a full buffer, simultaneous accept and reject, and decisions with nothing pending.

// File: rtl/derand_pkg.sv
package derand_pkg;
  typedef enum logic {RD_IDLE, RD_SHIFT} rd_state_t;
endpackage

// File: rtl/derand_slot_pick.sv
// Finds the lowest-numbered empty slot.
module derand_slot_pick #(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] occ,
  output logic                 any_free,
  output logic [SLOT_W-1:0]    free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        any_free = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/derand_idx_fifo.sv
// Small FIFO of slot indices.
module derand_idx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  // R4: order queues never lose or invent an entry
  assert_no_push_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/derand_serializer.sv
// Reads one slot out unit by unit, LSB first.
module derand_serializer
  import derand_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_UNITS = 10,
  parameter int UNIT_W    = 8,
  localparam int SLOT_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int EV_W    = NUM_UNITS * UNIT_W,
  localparam int UNIT_AW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_ok,
  input  logic [SLOT_W-1:0]  start_slot,
  input  logic [EV_W-1:0]    ev_data,
  output logic               take,
  output logic               done,
  output logic [SLOT_W-1:0]  cur_slot,
  output logic               ser_valid,
  output logic               ser_data,
  output logic [UNIT_AW-1:0] ser_unit
);
  localparam int BIT_W = (UNIT_W > 1) ? $clog2(UNIT_W) : 1;
  localparam int IDX_W = (EV_W > 1) ? $clog2(EV_W) : 1;

  rd_state_t          state_q, state_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [UNIT_AW-1:0] unit_q, unit_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [IDX_W-1:0]   bit_idx;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    unit_d  = unit_q;
    bit_d   = bit_q;
    take    = 1'b0;
    done    = 1'b0;
    case (state_q)
      RD_IDLE: begin
        if (start_ok) begin
          take    = 1'b1;
          state_d = RD_SHIFT;
          slot_d  = start_slot;
          unit_d  = '0;
          bit_d   = '0;
        end
      end
      RD_SHIFT: begin
        if (bit_q == BIT_W'(UNIT_W - 1)) begin
          bit_d = '0;
          if (unit_q == UNIT_AW'(NUM_UNITS - 1)) begin
            done    = 1'b1;
            state_d = RD_IDLE;
          end else begin
            unit_d = unit_q + 1'b1;
          end
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      slot_q  <= '0;
      unit_q  <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      unit_q  <= unit_d;
      bit_q   <= bit_d;
    end
  end

  assign bit_idx   = IDX_W'(unit_q) * IDX_W'(UNIT_W) + IDX_W'(bit_q);
  assign ser_data  = ev_data[bit_idx];
  assign ser_valid = (state_q == RD_SHIFT);
  assign ser_unit  = unit_q;
  assign cur_slot  = slot_q;

  // R7: an event is sent without holes, only valid unit numbers
  assert_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !done) |=> ser_valid);
  assert_unit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> (ser_unit <= UNIT_AW'(NUM_UNITS - 1)));
  // R8: at least one idle cycle between events
  assert_event_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ser_valid);
endmodule

// File: rtl/derand_buffer_ctrl.sv
module derand_buffer_ctrl #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_UNITS = 10,
  parameter int UNIT_W    = 8,
  parameter int ERR_W     = 8,
  localparam int EV_W    = NUM_UNITS * UNIT_W,
  localparam int UNIT_AW = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               l1_trig,
  input  logic [EV_W-1:0]    hit_pat,
  input  logic               l2_accept,
  input  logic               l2_reject,
  output logic               busy,
  output logic [ERR_W-1:0]   l1_err_cnt,
  output logic               ser_valid,
  output logic               ser_data,
  output logic [UNIT_AW-1:0] ser_unit
);
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ok_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok_n = rst_sync_q[1];

  logic [NUM_SLOTS-1:0] occ_q, occ_d;
  logic [ERR_W-1:0]     err_q, err_d;
  logic [EV_W-1:0]      slot_mem [NUM_SLOTS];
  logic                 any_free, store;
  logic [SLOT_W-1:0]    free_idx, pend_head, rd_head, cur_slot;
  logic                 pend_empty, pend_full, pend_pop;
  logic                 rd_empty, rd_full, rd_take, rd_done;
  logic                 acc, rej;

  derand_slot_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .occ(occ_q), .any_free(any_free), .free_idx(free_idx));

  assign busy     = !any_free;
  assign store    = l1_trig && any_free;
  assign pend_pop = (l2_accept || l2_reject) && !pend_empty;
  assign acc      = pend_pop && l2_accept;   // accept wins a tie
  assign rej      = pend_pop && !l2_accept;

  derand_idx_fifo #(.DEPTH(NUM_SLOTS), .W(SLOT_W)) u_pending (
    .clk(clk), .rst_n(rst_ok_n), .push(store), .din(free_idx),
    .pop(pend_pop), .dout(pend_head), .empty(pend_empty), .full(pend_full));

  derand_idx_fifo #(.DEPTH(NUM_SLOTS), .W(SLOT_W)) u_accepted (
    .clk(clk), .rst_n(rst_ok_n), .push(acc), .din(pend_head),
    .pop(rd_take), .dout(rd_head), .empty(rd_empty), .full(rd_full));

  derand_serializer #(.NUM_SLOTS(NUM_SLOTS), .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_ser (
    .clk(clk), .rst_n(rst_ok_n), .start_ok(!rd_empty), .start_slot(rd_head),
    .ev_data(slot_mem[cur_slot]), .take(rd_take), .done(rd_done),
    .cur_slot(cur_slot), .ser_valid(ser_valid), .ser_data(ser_data),
    .ser_unit(ser_unit));

  always_comb begin
    occ_d = occ_q;
    if (store)   occ_d[free_idx] = 1'b1;
    if (rej)     occ_d[pend_head] = 1'b0;
    if (rd_done) occ_d[cur_slot] = 1'b0;
    err_d = err_q;
    if (l1_trig && !any_free && (err_q != ERR_MAX)) err_d = err_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      occ_q <= '0;
      err_q <= '0;
    end else begin
      occ_q <= occ_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (store) slot_mem[free_idx] <= hit_pat;
  end

  assign l1_err_cnt = err_q;

  // R1: a trigger taken with no release in the same cycle adds one held slot
  assert_store_adds_slot_R1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (store && !rej && !rd_done) |=> ($countones(occ_q) == $past($countones(occ_q)) + 1));
  // R3: lost trigger counted, buffer untouched
  assert_lost_counted_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (l1_trig && busy && (err_q != ERR_MAX)) |=> (err_q == $past(err_q) + 1'b1));
  assert_lost_not_stored_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (l1_trig && busy && !rej && !rd_done) |=> (occ_q == $past(occ_q)));
  // R6: rejected slot freed next cycle
  assert_reject_frees_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rej |=> !occ_q[$past(pend_head)]);
  // R9: read-out slot freed after its last bit
  assert_readout_frees_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rd_done |=> !occ_q[$past(cur_slot)]);
  // R2: order queues never hold more entries than slots
  assert_queues_fit_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (pend_full || rd_full) |-> busy);
endmodule

// File: tb/tb_derand_buffer_ctrl.sv
module tb_derand_buffer_ctrl;
  localparam int NUM_SLOTS = 4;
  localparam int NUM_UNITS = 10;
  localparam int UNIT_W    = 4;
  localparam int ERR_W     = 4;
  localparam int EV_W      = NUM_UNITS * UNIT_W;
  localparam int UNIT_AW   = $clog2(NUM_UNITS);
  localparam int ERR_MAX   = (1 << ERR_W) - 1;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               l1_trig, l2_accept, l2_reject;
  logic [EV_W-1:0]    hit_pat;
  logic               busy, ser_valid, ser_data;
  logic [ERR_W-1:0]   l1_err_cnt;
  logic [UNIT_AW-1:0] ser_unit;

  always #5 clk = ~clk;

  derand_buffer_ctrl #(.NUM_SLOTS(NUM_SLOTS), .NUM_UNITS(NUM_UNITS),
                       .UNIT_W(UNIT_W), .ERR_W(ERR_W)) dut (
    .clk(clk), .rst_n(rst_n), .l1_trig(l1_trig), .hit_pat(hit_pat),
    .l2_accept(l2_accept), .l2_reject(l2_reject), .busy(busy),
    .l1_err_cnt(l1_err_cnt), .ser_valid(ser_valid), .ser_data(ser_data),
    .ser_unit(ser_unit));

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [EV_W-1:0] pend_q[$];
  logic [EV_W-1:0] exp_q[$];
  logic [EV_W-1:0] cur_ev;
  int occ_model = 0;
  int occ_chk   = 0;
  int err_model = 0;
  int bitcnt    = 0;
  bit prev_done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [EV_W-1:0] rnd_pat();
    return EV_W'({$urandom(), $urandom()});
  endfunction

  task automatic observe();
    bit done_now = 0;
    chk(busy == (occ_model == NUM_SLOTS), "R2 busy vs held slots", busy, occ_model == NUM_SLOTS);
    chk(l1_err_cnt == ERR_W'(err_model), "R3 lost trigger count", l1_err_cnt, err_model);
    occ_chk = occ_model;
    if (ser_valid) begin
      if (bitcnt == 0) begin
        chk(!prev_done, "R8 idle cycle between events", prev_done, 0);
        chk(exp_q.size() > 0, "R6 output only for accepted events", exp_q.size(), 1);
      end
      chk(ser_unit == UNIT_AW'(bitcnt / UNIT_W), "R7 unit number", ser_unit, bitcnt / UNIT_W);
      cur_ev[bitcnt] = ser_data;
      bitcnt++;
      if (bitcnt == EV_W) begin
        if (exp_q.size() > 0) begin
          logic [EV_W-1:0] e = exp_q.pop_front();
          chk(cur_ev == e, "R7 R8 event content and order", cur_ev, e);
        end
        bitcnt = 0;
        occ_model--;   // R9: slot free after last bit
        done_now = 1;
      end
    end else begin
      chk(bitcnt == 0, "R7 contiguous event", bitcnt, 0);
    end
    prev_done = done_now;
  endtask

  task automatic cycle(input bit t1, input logic [EV_W-1:0] pat, input bit acc, input bit rej);
    @(negedge clk);
    observe();
    l1_trig   = t1;
    hit_pat   = pat;
    l2_accept = acc;
    l2_reject = rej;
    if ((acc || rej) && pend_q.size() > 0) begin
      logic [EV_W-1:0] p = pend_q.pop_front();
      if (acc) exp_q.push_back(p);   // R5: accept wins a tie
      else occ_model--;
    end
    if (t1) begin
      if (occ_chk < NUM_SLOTS) begin
        pend_q.push_back(pat);
        occ_model++;
      end else if (err_model < ERR_MAX) begin
        err_model++;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, '0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; l1_trig = 0; l2_accept = 0; l2_reject = 0; hit_pat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy == 0, "R10 busy after reset", busy, 0);
    chk(ser_valid == 0, "R10 ser_valid after reset", ser_valid, 0);
    chk(l1_err_cnt == 0, "R10 error count after reset", l1_err_cnt, 0);

    // R4: decisions with nothing pending are ignored
    cycle(0, '0, 1, 0);
    cycle(0, '0, 0, 1);
    idle(5);

    // R1: fill every slot
    for (int i = 0; i < NUM_SLOTS; i++) cycle(1, rnd_pat(), 0, 0);
    // R3: triggers while full, past saturation
    for (int i = 0; i < ERR_MAX + 5; i++) cycle(1, rnd_pat(), 0, 0);
    idle(2);
    chk(l1_err_cnt == ERR_W'(ERR_MAX), "R3 saturation", l1_err_cnt, ERR_MAX);

    // R6: reject oldest two; R5: accept plus reject together
    cycle(0, '0, 0, 1);
    cycle(0, '0, 0, 1);
    cycle(0, '0, 1, 0);
    cycle(0, '0, 1, 1);
    // R1: acquisition during readout
    idle(10);
    cycle(1, rnd_pat(), 0, 0);
    cycle(1, rnd_pat(), 1, 0);
    idle(150);
    cycle(0, '0, 0, 1);
    idle(5);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      bit t  = ($urandom_range(9) == 0);
      bit a  = ($urandom_range(39) == 0);
      bit r  = ($urandom_range(19) == 0);
      cycle(t, rnd_pat(), a, r);
    end
    while (pend_q.size() > 0) cycle(0, '0, 0, 1);
    idle(400);
    chk(exp_q.size() == 0, "R8 every accepted event read out", exp_q.size(), 0);
    chk(busy == 0 && occ_model == 0, "R9 all slots free at end", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule